// File: doc/BRIEF.md
# Preemptive Priority Interrupt Controller

This block arbitrates a set of interrupt lines for a single processor core. Each line has a programmable priority and a mask bit, and each is always in one of three states: inactive, pending or active. A one-cycle event pulse on an unmasked inactive line makes it pending. The controller raises a request to the core whenever the best pending line outranks every line that is already active. The core takes that line with an acknowledge pulse and later retires it with an end-of-interrupt command that names the line.

Several lines can be active at once. A higher-priority arrival preempts the running handler. The preempted line stays active and becomes the running one again as soon as the line above it is retired. The running line is reported continuously on the ports.

Configuration is one write port. A write sets the priority and the mask of one line together, and it takes effect at the clock edge where the write strobe is sampled.

Top module: `prio_intc`

## Requirements
- R1: After reset every line is inactive, unmasked and at priority zero, so `irq_o` and `run_valid_o` are 0.
- R2: An event pulse on an unmasked inactive line makes it pending at that clock edge.
- R3: `irq_o` is 1 only when the best pending priority is strictly greater than the highest active priority. When no line is active, that level counts as zero, so a pending line at priority zero never raises a request on its own.
- R4: `ack_id_o` combinationally names the pending line with the highest priority. On equal priorities the lower line number is chosen.
- R5: An acknowledge sampled while `irq_o` is 1 moves the line named by `ack_id_o` to active, and that line is running from the next cycle. An acknowledge sampled while `irq_o` is 0 changes nothing.
- R6: The running line (`run_id_o`, qualified by `run_valid_o`) is the active line with the highest priority. A preempted line stays active and is running again once the higher line is retired.
- R7: An end-of-interrupt naming an active line makes that line inactive. An end-of-interrupt naming a line that is not active is ignored.
- R8: Writing mask = 1 to a pending line returns it to inactive, so clearing the mask later does not bring the request back. A masked line ignores events.
- R9: An event on a line that is already pending or active has no effect. After an active line is retired it is inactive, not pending.
- R10: An acknowledge and an end-of-interrupt for a different line in the same cycle both take effect.
- R11: If an acknowledge and a mask write hit the same pending line in the same cycle, the acknowledge wins and the line becomes active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_i | input | NUM_LINES | One-cycle event pulse per line |
| cfg_we_i | input | 1 | Write strobe for the configuration of one line |
| cfg_id_i | input | ID_W | Line being configured |
| cfg_prio_i | input | PRIO_W | Priority value to write |
| cfg_mask_i | input | 1 | Mask bit to write (1 = masked) |
| irq_o | output | 1 | Request to the core |
| ack_i | input | 1 | Acknowledge from the core |
| ack_id_o | output | ID_W | Line that an acknowledge would take |
| eoi_i | input | 1 | End-of-interrupt strobe |
| eoi_id_i | input | ID_W | Line being retired |
| run_valid_o | output | 1 | At least one line is active |
| run_id_o | output | ID_W | Running line (highest-priority active) |

## Verification
Two pairs of operations can arrive in the same cycle, and both are tested. In the first, a higher-priority line is acknowledged while the running line is retired by an end-of-interrupt (R10). The bench drives both strobes in the same cycle. It then expects the new line to be running, and it expects no line to be active once that new line is retired, which shows that the old line really left the active set. In the second, an acknowledge and a mask write land on the same pending line (R11). The line must come out active and running, because the acknowledge has precedence over the mask.

// File: rtl/intc_pkg.sv
package intc_pkg;
  typedef enum logic [1:0] {
    LN_IDLE = 2'd0,
    LN_PEND = 2'd1,
    LN_ACTV = 2'd2
  } line_st_e;
endpackage

// File: rtl/intc_line.sv
module intc_line
  import intc_pkg::*;
#(
  parameter int PRIO_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              evt,
  input  logic              cfg_hit,
  input  logic [PRIO_W-1:0] cfg_prio,
  input  logic              cfg_mask,
  input  logic              take,
  input  logic              retire,
  output logic              pend,
  output logic              actv,
  output logic [PRIO_W-1:0] prio
);
  line_st_e          st_q, st_d;
  logic              mask_q;
  logic [PRIO_W-1:0] prio_q;
  logic              eff_mask;

  // A mask written in this cycle already governs this edge.
  assign eff_mask = cfg_hit ? cfg_mask : mask_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      LN_IDLE: if (evt && !eff_mask) st_d = LN_PEND;
      LN_PEND: begin
        if (take)          st_d = LN_ACTV;
        else if (eff_mask) st_d = LN_IDLE;
      end
      LN_ACTV: if (retire) st_d = LN_IDLE;
      default: st_d = LN_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= LN_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= 1'b0;
      prio_q <= '0;
    end else if (cfg_hit) begin
      mask_q <= cfg_mask;
      prio_q <= cfg_prio;
    end
  end

  assign pend = (st_q == LN_PEND);
  assign actv = (st_q == LN_ACTV);
  assign prio = prio_q;

  p_event_pends_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LN_IDLE && evt && !mask_q && !cfg_hit) |=> (st_q == LN_PEND));

  p_retire_idles_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LN_ACTV && retire) |=> (st_q == LN_IDLE));

  p_pend_unmasked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LN_PEND) |-> !mask_q);

  p_masked_ignores_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == LN_IDLE && mask_q && !cfg_hit) |=> (st_q == LN_IDLE));
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int N      = 16,
  parameter int PRIO_W = 4,
  localparam int ID_W  = $clog2(N)
) (
  input  logic [N-1:0]             valid,
  input  logic [N-1:0][PRIO_W-1:0] prio,
  output logic                     found,
  output logic [ID_W-1:0]          id,
  output logic [PRIO_W-1:0]        best
);
  // Scan from the top index down; ">=" lets a lower index win a tie.
  always_comb begin
    found = 1'b0;
    id    = '0;
    best  = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (valid[i] && (!found || prio[i] >= best)) begin
        found = 1'b1;
        id    = ID_W'(i);
        best  = prio[i];
      end
    end
  end
endmodule

// File: rtl/prio_intc.sv
module prio_intc #(
  parameter int NUM_LINES = 16,
  parameter int PRIO_W    = 4,
  localparam int ID_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_LINES-1:0] evt_i,
  input  logic                 cfg_we_i,
  input  logic [ID_W-1:0]      cfg_id_i,
  input  logic [PRIO_W-1:0]    cfg_prio_i,
  input  logic                 cfg_mask_i,
  output logic                 irq_o,
  input  logic                 ack_i,
  output logic [ID_W-1:0]      ack_id_o,
  input  logic                 eoi_i,
  input  logic [ID_W-1:0]      eoi_id_i,
  output logic                 run_valid_o,
  output logic [ID_W-1:0]      run_id_o
);
  logic [NUM_LINES-1:0]             pend_v, actv_v;
  logic [NUM_LINES-1:0][PRIO_W-1:0] prio_v;
  logic                             p_found, a_found;
  logic [ID_W-1:0]                  p_id, a_id;
  logic [PRIO_W-1:0]                p_prio, a_prio, act_lvl;
  logic                             grant;

  assign grant = ack_i && irq_o;

  for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
    intc_line #(.PRIO_W(PRIO_W)) u_line (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (evt_i[g]),
      .cfg_hit  (cfg_we_i && cfg_id_i == ID_W'(g)),
      .cfg_prio (cfg_prio_i),
      .cfg_mask (cfg_mask_i),
      .take     (grant && p_id == ID_W'(g)),
      .retire   (eoi_i && eoi_id_i == ID_W'(g)),
      .pend     (pend_v[g]),
      .actv     (actv_v[g]),
      .prio     (prio_v[g])
    );
  end

  intc_arb #(.N(NUM_LINES), .PRIO_W(PRIO_W)) u_pend_arb (
    .valid (pend_v),
    .prio  (prio_v),
    .found (p_found),
    .id    (p_id),
    .best  (p_prio)
  );

  intc_arb #(.N(NUM_LINES), .PRIO_W(PRIO_W)) u_actv_arb (
    .valid (actv_v),
    .prio  (prio_v),
    .found (a_found),
    .id    (a_id),
    .best  (a_prio)
  );

  // With nothing active the threshold is zero, so priority zero never asks.
  assign act_lvl     = a_found ? a_prio : '0;
  assign irq_o       = p_found && (p_prio > act_lvl);
  assign ack_id_o    = p_id;
  assign run_valid_o = a_found;
  assign run_id_o    = a_id;

  p_grant_runs_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_i && irq_o && !cfg_we_i) |=> (run_valid_o && run_id_o == $past(ack_id_o)));

  p_no_ack_no_change_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_o && !eoi_i && !cfg_we_i) |=> ($stable(run_valid_o) && $stable(run_id_o)));

  p_irq_needs_pend_r3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (pend_v != '0));

  p_states_disjoint_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_v & actv_v) == '0);
endmodule

// File: tb/tb_prio_intc.sv
`timescale 1ns/100ps
module tb_prio_intc;
  localparam int N  = 16;
  localparam int PW = 4;
  localparam int IW = $clog2(N);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  evt_i = '0;
  logic          cfg_we_i = 1'b0;
  logic [IW-1:0] cfg_id_i = '0;
  logic [PW-1:0] cfg_prio_i = '0;
  logic          cfg_mask_i = 1'b0;
  logic          irq_o;
  logic          ack_i = 1'b0;
  logic [IW-1:0] ack_id_o;
  logic          eoi_i = 1'b0;
  logic [IW-1:0] eoi_id_i = '0;
  logic          run_valid_o;
  logic [IW-1:0] run_id_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  prio_intc dut (
    .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
    .cfg_we_i(cfg_we_i), .cfg_id_i(cfg_id_i), .cfg_prio_i(cfg_prio_i),
    .cfg_mask_i(cfg_mask_i), .irq_o(irq_o), .ack_i(ack_i),
    .ack_id_o(ack_id_o), .eoi_i(eoi_i), .eoi_id_i(eoi_id_i),
    .run_valid_o(run_valid_o), .run_id_o(run_id_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic cfg(input int id, input int pr, input bit m);
    cfg_we_i = 1'b1; cfg_id_i = IW'(id); cfg_prio_i = PW'(pr); cfg_mask_i = m;
    cyc();
    cfg_we_i = 1'b0;
  endtask

  task automatic fire(input logic [N-1:0] v);
    evt_i = v;
    cyc();
    evt_i = '0;
  endtask

  task automatic ack();
    ack_i = 1'b1;
    cyc();
    ack_i = 1'b0;
  endtask

  task automatic eoi(input int id);
    eoi_i = 1'b1; eoi_id_i = IW'(id);
    cyc();
    eoi_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 irq after reset", irq_o, 0);
    chk("R1 run_valid after reset", run_valid_o, 0);
    fire(16'h0001);
    chk("R3 prio-zero pending gives no irq", irq_o, 0);
    cfg(0, 0, 1'b1);
    cfg(0, 0, 1'b0);
  endtask

  task automatic t_select();
    cfg(3, 5, 1'b0); cfg(7, 9, 1'b0); cfg(9, 9, 1'b0);
    fire(16'h0288);
    chk("R2 event makes pending, irq", irq_o, 1);
    chk("R4 tie picks lower id", ack_id_o, 7);
    ack();
    chk("R5 acked line running", run_id_o, 7);
    chk("R3 equal priority gives no irq", irq_o, 0);
    ack();
    chk("R5 ack without irq ignored", run_id_o, 7);
    eoi(7);
    chk("R4 next pending chosen", ack_id_o, 9);
    chk("R3 irq with nothing active", irq_o, 1);
    ack(); eoi(9);
    chk("R4 remaining pending", ack_id_o, 3);
    ack(); eoi(3);
    chk("R7 all retired", run_valid_o, 0);
    chk("R7 no irq left", irq_o, 0);
  endtask

  task automatic t_preempt();
    cfg(2, 4, 1'b0); cfg(5, 10, 1'b0);
    fire(16'h0004); ack();
    chk("R6 low line running", run_id_o, 2);
    fire(16'h0020);
    chk("R3 higher pending requests", irq_o, 1);
    ack();
    chk("R6 preempting line running", run_id_o, 5);
    eoi(5);
    chk("R6 preempted line resumes", run_id_o, 2);
    chk("R6 still active", run_valid_o, 1);
    eoi(11);
    chk("R7 eoi on non-active ignored", run_id_o, 2);
    chk("R7 eoi on non-active keeps valid", run_valid_o, 1);
    eoi(2);
    chk("R7 retired", run_valid_o, 0);
  endtask

  task automatic t_mask();
    cfg(4, 6, 1'b0);
    fire(16'h0010);
    chk("R2 pending line requests", irq_o, 1);
    cfg(4, 6, 1'b1);
    chk("R8 mask drops pending", irq_o, 0);
    cfg(4, 6, 1'b0);
    chk("R8 unmask does not restore", irq_o, 0);
    cfg(4, 6, 1'b1);
    fire(16'h0010);
    chk("R8 masked ignores event", irq_o, 0);
    cfg(4, 6, 1'b0);
    chk("R8 masked event not latched", irq_o, 0);
  endtask

  task automatic t_repeat();
    cfg(6, 3, 1'b0);
    fire(16'h0040); ack();
    fire(16'h0040);
    chk("R9 event on active no irq", irq_o, 0);
    eoi(6);
    chk("R9 retired not pending", irq_o, 0);
    chk("R9 nothing active", run_valid_o, 0);
  endtask

  task automatic t_ack_eoi();
    cfg(1, 2, 1'b0); cfg(8, 7, 1'b0);
    fire(16'h0002); ack();
    fire(16'h0100);
    chk("R10 request for higher line", ack_id_o, 8);
    ack_i = 1'b1; eoi_i = 1'b1; eoi_id_i = 1;
    cyc();
    ack_i = 1'b0; eoi_i = 1'b0;
    chk("R10 acked line running", run_id_o, 8);
    eoi(8);
    chk("R10 old line also retired", run_valid_o, 0);
  endtask

  task automatic t_ack_mask();
    cfg(10, 5, 1'b0);
    fire(16'h0400);
    ack_i = 1'b1;
    cfg_we_i = 1'b1; cfg_id_i = 10; cfg_prio_i = 5; cfg_mask_i = 1'b1;
    cyc();
    ack_i = 1'b0; cfg_we_i = 1'b0;
    chk("R11 ack wins over mask", run_id_o, 10);
    chk("R11 line active", run_valid_o, 1);
    eoi(10);
    cfg(10, 5, 1'b0);
    chk("R7 final idle", run_valid_o, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc();
    t_reset();
    t_select();
    t_preempt();
    t_mask();
    t_repeat();
    t_ack_eoi();
    t_ack_mask();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule